// File: doc/BRIEF.md
# I/O Peripheral Chip-Select Decoder

This block sits behind a host I/O cycle engine. It turns a 16-bit I/O address and its read/write cycle qualifiers into active-low chip selects, pass-through address lines and active-low read and write strobes for up to four external 8-bit peripherals. Each select has its own base address, held in a high-byte and a low-byte register. The low-byte register also carries a disable bit and a set-once lock bit. A mode bit trades select count against address width: mode 0 gives four selects that each decode a 4-port window with two address lines, and mode 1 gives two selects that each decode a 16-port window with four address lines.

Configuration arrives through a simple synchronous write port. Select k has its high byte at index 2k and its low byte at index 2k+1. The mode register is at index 8 and the qualification register at index 9; each keeps its setting in bit 0. The decode path from address to outputs is combinational, so the outputs follow the current host cycle with no added latency. A configuration write takes effect from the clock edge that captures it.

Top module: `io_cs_decoder`

## Requirements
- R1: After reset, every base byte is 0x00, every low byte is 0x01 (select disabled, unlocked), mode is 0 and qualification is off. As a result cs_n_o reads 4'hF and rd_n_o and wr_n_o read 1 for any input.
- R2: In mode 0, select k matches when addr_i[15:8] equals its high byte and addr_i[7:2] equals bits [7:2] of its low byte. xa_o is {2'b00, addr_i[1:0]}.
- R3: In mode 1, only selects 0 and 1 can match, and cs_n_o[3:2] stay 1. A select matches on addr_i[15:8] against its high byte and on addr_i[7:4] against low-byte bits [7:4]. xa_o is addr_i[3:0].
- R4: Writing config index 8 sets the mode from bit 0 of the write data (0 = four selects, 1 = two selects).
- R5: When bit 0 of config index 9 is 1, a match also requires addr_i[15:12] to be 0.
- R6: A chip select is low only while io_rd_i or io_wr_i is high in the cycle that presents the matching address.
- R7: A select whose low-byte bit 0 is 1 never asserts.
- R8: Once low-byte bit 1 (lock) of a select is 1, writes to that select's high and low bytes are ignored. This covers writes to the disable bit and to the lock bit itself.
- R9: Only reset clears a lock bit; after reset the select's bytes can be written again.
- R10: rd_n_o is low exactly when io_rd_i is high and some select asserts. wr_n_o behaves the same way with io_wr_i.
- R11: When several enabled selects match, only the lowest-numbered one asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on or hard reset) |
| addr_i | input | 16 | Host I/O address |
| io_rd_i | input | 1 | Host I/O read cycle active |
| io_wr_i | input | 1 | Host I/O write cycle active |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cs_n_o | output | 4 | Active-low chip selects |
| xa_o | output | 4 | Pass-through address lines |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |

## Verification
Directed addresses sit just inside and just outside each window. This shows whether the decoder compares addr_i[1:0] in mode 0 or addr_i[3:2] in mode 1, where it should not. Overlapping bases separate priority from the disable bit, and addresses with a nonzero top nibble isolate the qualification bit. Writes attempted after locking check the lock, and a reset in the middle of the run checks how the lock is cleared. Random addresses drawn near the programmed bases, with random qualifiers and random configuration writes interleaved, are compared against a bench model of the register file and the decode.

// File: rtl/io_cs_pkg.sv
package io_cs_pkg;
  localparam int NUM_SEL  = 4;
  localparam int ADDR_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int M0_LSB   = 2;   // mode 0 window: 4 ports
  localparam int M1_LSB   = 4;   // mode 1 window: 16 ports
  localparam int QUAL_LSB = 12;
  localparam int XA_W     = M1_LSB;
  localparam int CFG_AW   = $clog2(2 * NUM_SEL + 2);
  localparam int DIS_BIT  = 0;
  localparam int LOCK_BIT = 1;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } base_t;
endpackage

// File: rtl/io_cs_cfg.sv
module io_cs_cfg
  import io_cs_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CFG_AW-1:0]       waddr_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output base_t [NSEL-1:0]        base_o,
  output logic                    mode_o,
  output logic                    qual_o
);
  localparam logic [CFG_AW-1:0] MODE_A = CFG_AW'(2 * NSEL);
  localparam logic [CFG_AW-1:0] QUAL_A = CFG_AW'(2 * NSEL + 1);

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    localparam logic [CFG_AW-1:0] HI_A = CFG_AW'(2 * k);
    localparam logic [CFG_AW-1:0] LO_A = CFG_AW'(2 * k + 1);
    base_t r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r.hi <= '0;
        r.lo <= BYTE_W'(1 << DIS_BIT);
      end else if (we_i && !r.lo[LOCK_BIT]) begin
        if (waddr_i == HI_A) r.hi <= wdata_i;
        else if (waddr_i == LO_A) r.lo <= wdata_i;
      end
    end

    assign base_o[k] = r;

    // R8
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r.lo[LOCK_BIT] |=> ($stable(r) && r.lo[LOCK_BIT]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= 1'b0;
      qual_o <= 1'b0;
    end else if (we_i) begin
      if (waddr_i == MODE_A) mode_o <= wdata_i[0];
      if (waddr_i == QUAL_A) qual_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/io_cs_match.sv
module io_cs_match
  import io_cs_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  base_t [NSEL-1:0]  base_i,
  input  logic              mode_i,
  input  logic              qual_i,
  output logic [NSEL-1:0]   hit_o
);
  localparam int HI_LSB = ADDR_W - BYTE_W;

  logic q_ok;
  assign q_ok = !qual_i || (addr_i[ADDR_W-1:QUAL_LSB] == '0);

  for (genvar k = 0; k < NSEL; k++) begin : g_cmp
    localparam bit IN_M1 = (k < NSEL / 2);
    logic hi_ok, m0_ok, m1_ok, lo_ok, avail;
    assign hi_ok = addr_i[ADDR_W-1:HI_LSB] == base_i[k].hi;
    assign m0_ok = addr_i[BYTE_W-1:M0_LSB] == base_i[k].lo[BYTE_W-1:M0_LSB];
    assign m1_ok = addr_i[BYTE_W-1:M1_LSB] == base_i[k].lo[BYTE_W-1:M1_LSB];
    assign lo_ok = mode_i ? m1_ok : m0_ok;
    assign avail = !mode_i || IN_M1;
    assign hit_o[k] = hi_ok && lo_ok && q_ok && avail && !base_i[k].lo[DIS_BIT];
  end
endmodule

// File: rtl/io_cs_prio.sv
module io_cs_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
endmodule

// File: rtl/io_cs_decoder.sv
module io_cs_decoder
  import io_cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [NUM_SEL-1:0] cs_n_o,
  output logic [XA_W-1:0]   xa_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  base_t [NUM_SEL-1:0] base;
  logic                mode, qual, cyc, any_gnt;
  logic [NUM_SEL-1:0]  hit, req, gnt;

  io_cs_cfg #(.NSEL(NUM_SEL)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .waddr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .base_o(base), .mode_o(mode), .qual_o(qual)
  );

  io_cs_match #(.NSEL(NUM_SEL)) u_match (
    .addr_i(addr_i), .base_i(base), .mode_i(mode), .qual_i(qual), .hit_o(hit)
  );

  assign cyc = io_rd_i || io_wr_i;
  assign req = hit & {NUM_SEL{cyc}};

  io_cs_prio #(.N(NUM_SEL)) u_prio (.req_i(req), .gnt_o(gnt));

  assign any_gnt = |gnt;
  assign cs_n_o  = ~gnt;
  assign rd_n_o  = !(io_rd_i && any_gnt);
  assign wr_n_o  = !(io_wr_i && any_gnt);
  assign xa_o    = mode ? addr_i[XA_W-1:0]
                        : {{(XA_W-M0_LSB){1'b0}}, addr_i[M0_LSB-1:0]};

  // R6
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc |-> (cs_n_o == '1));
  // R11
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R3
  m1_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode |-> (&cs_n_o[NUM_SEL-1:NUM_SEL/2]));
  // R10
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> (cs_n_o != '1));
endmodule

// File: tb/io_cs_decoder_bench.sv
module io_cs_decoder_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_ni = 0;
  logic [15:0] addr = 0;
  logic        io_rd = 0, io_wr = 0, cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [3:0]  cs_n, xa;
  logic        rd_n, wr_n;

  int tests = 0, fails = 0;
  logic [7:0] hi_m [4];
  logic [7:0] lo_m [4];
  logic mode_m, qual_m;

  always #(CLK_P/2) clk = ~clk;

  io_cs_decoder u_io_cs_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cs_n_o(cs_n), .xa_o(xa), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  function automatic void model_reset();
    for (int k = 0; k < 4; k++) begin hi_m[k] = 8'h00; lo_m[k] = 8'h01; end
    mode_m = 0; qual_m = 0;
  endfunction

  function automatic logic [3:0] exp_cs(logic [15:0] a, logic rd, logic wr);
    logic [3:0] r = 4'hF;
    if (!(rd || wr)) return r;
    for (int k = 0; k < 4; k++) begin
      logic h;
      if (mode_m && k >= 2) continue;
      h = (a[15:8] == hi_m[k]) && !lo_m[k][0] && (!qual_m || a[15:12] == 4'h0);
      h = h && (mode_m ? (a[7:4] == lo_m[k][7:4]) : (a[7:2] == lo_m[k][7:2]));
      if (h) begin r[k] = 1'b0; return r; end
    end
    return r;
  endfunction

  task automatic cfg_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 4'd8) begin
      if (!lo_m[a[3:1]][1]) begin
        if (a[0]) lo_m[a[3:1]] = d; else hi_m[a[3:1]] = d;
      end
    end else if (a == 4'd8) mode_m = d[0];
    else if (a == 4'd9) qual_m = d[0];
  endtask

  task automatic probe(string tag, logic [15:0] a, logic rd, logic wr);
    logic [3:0] ecs, exa;
    logic erd, ewr;
    @(negedge clk);
    addr = a; io_rd = rd; io_wr = wr;
    #(CLK_P/4);
    ecs = exp_cs(a, rd, wr);
    exa = mode_m ? a[3:0] : {2'b00, a[1:0]};
    erd = !(rd && ecs != 4'hF);
    ewr = !(wr && ecs != 4'hF);
    tests++;
    if (cs_n !== ecs || xa !== exa || rd_n !== erd || wr_n !== ewr) begin
      fails++;
      $display("FAIL %s addr=%h act cs=%b xa=%h rd=%b wr=%b exp cs=%b xa=%h rd=%b wr=%b",
               tag, a, cs_n, xa, rd_n, wr_n, ecs, exa, erd, ewr);
    end
    io_rd = 0; io_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    #(CLK_P/4);
    model_reset();
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    #(CLK_P * 2);
    rst_ni = 1;
    // R1: reset state, base 0 disabled
    probe("R1", 16'h0000, 1, 0);
    probe("R1", 16'h0003, 0, 1);

    cfg_write(4'd0, 8'h03); cfg_write(4'd1, 8'h00);
    cfg_write(4'd2, 8'h03); cfg_write(4'd3, 8'h10);
    cfg_write(4'd4, 8'h13); cfg_write(4'd5, 8'h20);
    cfg_write(4'd6, 8'h03); cfg_write(4'd7, 8'h04);
    // R2 mode 0 windows and pass-through
    probe("R2", 16'h0302, 1, 0);
    probe("R2", 16'h0305, 1, 0);
    probe("R2", 16'h0308, 1, 0);
    probe("R2", 16'h1323, 0, 1);
    // R6 no cycle
    probe("R6", 16'h0302, 0, 0);
    // R10 strobes
    probe("R10", 16'h0311, 0, 1);
    probe("R10", 16'h0400, 1, 0);
    // R5 qualification
    cfg_write(4'd9, 8'h01);
    probe("R5", 16'h1321, 1, 0);
    probe("R5", 16'h0301, 1, 0);
    cfg_write(4'd9, 8'h00);
    probe("R5", 16'h1321, 1, 0);
    // R4 R3 mode 1
    cfg_write(4'd8, 8'h01);
    probe("R3", 16'h031A, 1, 0);
    probe("R3", 16'h0307, 0, 1);
    probe("R3", 16'h132F, 1, 0);
    cfg_write(4'd8, 8'h00);
    probe("R4", 16'h0307, 0, 1);
    // R11 overlap sel3 with sel0
    cfg_write(4'd7, 8'h00);
    probe("R11", 16'h0301, 1, 0);
    // R7 disable sel0
    cfg_write(4'd1, 8'h01);
    probe("R7", 16'h0301, 1, 0);
    cfg_write(4'd7, 8'h01);
    probe("R7", 16'h0301, 0, 1);
    cfg_write(4'd1, 8'h00);
    // R8 lock sel1
    cfg_write(4'd3, 8'h12);
    cfg_write(4'd2, 8'h05);
    cfg_write(4'd3, 8'h11);
    probe("R8", 16'h0312, 1, 0);
    probe("R8", 16'h0500, 1, 0);
    cfg_write(4'd3, 8'h10);
    cfg_write(4'd2, 8'h06);
    probe("R8", 16'h0313, 0, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int s;
      if (($urandom % 8) == 0)
        cfg_write(4'($urandom % 10), 8'($urandom & 32'hF5));
      s = $urandom % 4;
      a = {hi_m[s], lo_m[s][7:4], 4'($urandom)};
      if (($urandom % 4) == 0) a = 16'($urandom);
      if (($urandom % 6) == 0) a[15:12] = 4'($urandom);
      probe(mode_m ? "R3" : "R2", a, 1'($urandom), 1'($urandom));
    end

    // R9 reset clears lock
    do_reset();
    probe("R1", 16'h0000, 1, 0);
    cfg_write(4'd2, 8'h05); cfg_write(4'd3, 8'h00);
    probe("R9", 16'h0502, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule